// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an on-chip requester and an external asynchronous static RAM. Each request it accepts becomes one complete, correctly timed read or write cycle on the RAM pins. The RAM pins are address, a bidirectional data bus, and active-low chip select, output enable and write strobe. The requester sees a request strobe with a write flag, address and write data. It also sees a ready level, read data, and a one-cycle pulse that marks read data as valid.

Every analog timing minimum is given as a nanosecond parameter. A package function converts each one into clock cycles by rounding up against the clock period parameter. After reset the block holds ready low and leaves every RAM strobe inactive until the power-up interval has elapsed.

Writes are strobe-controlled, with output enable held high. The chip select and the address go out one cycle before the write strobe falls, and the write strobe is held for a fixed pulse. A hold cycle follows before the bus is released. The total write length also covers the case where output enable stays low, in which the cycle must span the strobe-to-high-Z time plus the data setup time.

Top module: `sram_ctl`

## Requirements
- R1: From reset release, ready stays low and chip select stays high for exactly N_PWR = ceil(T_PWR_NS / CLK_NS) clock edges, and ready first reads high after edge N_PWR.
- R2: A request is accepted only at an edge where ready is high. A request held while ready is low (during power-up or during an access) starts no RAM cycle.
- R3: A read holds chip select and output enable low, with the write strobe high, for exactly N_RD = the maximum of the rounded cycle-time, address-access, select-access and output-enable-access counts. The bus is sampled at the edge that ends that window, and rvalid is high for exactly one cycle with that data.
- R4: For a write, the address and the low chip select are present for one cycle before the write strobe falls. The address does not change while the write strobe is low.
- R5: The write strobe is low for exactly N_PW = max(ceil(T_PWE_NS/CLK_NS), ceil(T_SD_NS/CLK_NS)) cycles.
- R6: The controller drives the data bus only while the write strobe is low and during the hold phase after it. Output enable is never low while the write strobe is low or in the cycle right after it. During the strobe the bus carries the accepted write data.
- R7: A write keeps chip select low for exactly 1 + N_PW + N_TL cycles, where N_TL = max(1, N_WC - 1 - N_PW) and N_WC = max(ceil(T_WC_NS/CLK_NS), ceil((T_HZWE_NS+T_SD_NS)/CLK_NS)).
- R8: Two consecutive changes of the RAM address are at least ceil(T_RC_NS/CLK_NS) cycles apart.
- R9: In reset and whenever ready is high, chip select, output enable and write strobe are all high.
- R10: Data written to an address reads back unchanged on a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, taken when ready is high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | Idle and powered up, request may be given |
| rdata | output | DATA_W | Read data, valid with rvalid |
| rvalid | output | 1 | One-cycle read-data-valid pulse |
| sram_addr | output | ADDR_W | RAM address |
| sram_dq | inout | DATA_W | RAM bidirectional data bus |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |

## Verification
A sequencer stuck in a wrong phase or with an off-by-one count shows at the pins within a single access. The strobe lengths come out one cycle long or short at the rising edge of the write strobe or output enable. A read window that ends too early captures data the RAM model has not yet made valid, so rdata is wrong at the very next rvalid pulse. A write that drives the wrong data, or lets the address move, corrupts the model array and shows on the next read of that address. A power-up counter that ends early or late moves the first ready edge by a measurable number of cycles.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IDLE,
    ST_RD,
    ST_WSU,
    ST_WPW,
    ST_WHD
  } seq_st_t;

  // round a nanosecond minimum up to whole clock cycles, never below one
  function automatic int ns_to_cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_pwrup.sv
module sram_ctl_pwrup #(
  parameter int N_PWR = 200000,
  localparam int CW = $clog2(N_PWR + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic expired
);
  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(N_PWR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int N_RD = 3,
  parameter int N_PW = 2,
  parameter int N_TL = 1,
  localparam int N_WTOT = 1 + N_PW + N_TL,
  localparam int CW = $clog2(imax(imax(N_RD, N_PW), N_WTOT) + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_expired,
  input  logic req,
  input  logic req_wr,
  output logic accept,
  output logic rd_sample,
  output logic ready,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic drv
);
  seq_st_t st;
  logic [CW-1:0] cnt;
  logic cnt_zero;

  assign cnt_zero  = (cnt == '0);
  assign ready     = (st == ST_IDLE);
  assign accept    = ready && req;
  assign rd_sample = (st == ST_RD) && cnt_zero;

  // strobes decoded from the state register only
  assign ce_n = !((st == ST_RD) || (st == ST_WSU) || (st == ST_WPW) || (st == ST_WHD));
  assign oe_n = (st != ST_RD);
  assign we_n = (st != ST_WPW);
  assign drv  = (st == ST_WPW) || (st == ST_WHD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_PWR;
      cnt <= '0;
    end else begin
      case (st)
        ST_PWR:  if (pwr_expired) st <= ST_IDLE;
        ST_IDLE: if (req) begin
          if (req_wr) st <= ST_WSU;
          else begin
            st  <= ST_RD;
            cnt <= CW'(N_RD - 1);
          end
        end
        ST_RD: begin
          if (cnt_zero) st <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_WSU: begin
          st  <= ST_WPW;
          cnt <= CW'(N_PW - 1);
        end
        ST_WPW: begin
          if (cnt_zero) begin
            st  <= ST_WHD;
            cnt <= CW'(N_TL - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WHD: begin
          if (cnt_zero) st <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // checker state: run lengths and a sticky power flag
  logic [CW-1:0] we_run, ce_run;
  logic pwr_seen, wr_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0; ce_run <= '0; pwr_seen <= 1'b0; wr_seen <= 1'b0;
    end else begin
      we_run <= we_n ? '0 : we_run + 1'b1;
      ce_run <= ce_n ? '0 : ce_run + 1'b1;
      if (pwr_expired) pwr_seen <= 1'b1;
      if (accept) wr_seen <= req_wr;
    end
  end

  // R1
  pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_seen |-> (ce_n && !ready));
  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_run == CW'(N_PW)));
  // R7
  wr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ce_n) && wr_seen) |-> (ce_run == CW'(N_WTOT)));
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 5,
  parameter int T_PWR_NS  = 1000000,
  parameter int T_RC_NS   = 12,
  parameter int T_AA_NS   = 12,
  parameter int T_ACE_NS  = 12,
  parameter int T_DOE_NS  = 6,
  parameter int T_WC_NS   = 12,
  parameter int T_PWE_NS  = 10,
  parameter int T_SD_NS   = 7,
  parameter int T_HZWE_NS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] sram_addr,
  inout  wire  [DATA_W-1:0] sram_dq,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n
);
  localparam int N_PWR = ns_to_cyc(T_PWR_NS, CLK_NS);
  localparam int N_RD  = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                              imax(ns_to_cyc(T_ACE_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS)));
  localparam int N_PW  = imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS));
  localparam int N_WC  = imax(ns_to_cyc(T_WC_NS, CLK_NS), ns_to_cyc(T_HZWE_NS + T_SD_NS, CLK_NS));
  localparam int N_TL  = imax(1, N_WC - 1 - N_PW);

  logic pwr_expired, accept, rd_sample, drv;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic rvalid_q;

  sram_ctl_pwrup #(.N_PWR(N_PWR)) u_pwr (
    .clk(clk), .rst_n(rst_n), .expired(pwr_expired)
  );

  sram_ctl_seq #(.N_RD(N_RD), .N_PW(N_PW), .N_TL(N_TL)) u_seq (
    .clk(clk), .rst_n(rst_n), .pwr_expired(pwr_expired),
    .req(req), .req_wr(req_wr), .accept(accept), .rd_sample(rd_sample),
    .ready(ready), .ce_n(sram_ce_n), .oe_n(sram_oe_n), .we_n(sram_we_n), .drv(drv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_sample;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_sample) rdata_q <= sram_dq;
    end
  end

  assign sram_addr = addr_q;
  assign sram_dq   = drv ? wdata_q : 'z;
  assign rdata     = rdata_q;
  assign rvalid    = rvalid_q;

  // R4
  wr_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> $stable(sram_addr));
  // R3
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
  // R2
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !$stable(sram_addr)) |-> $past(ready));
endmodule

// File: tb/sram_ctl_test.sv
`timescale 1ns/1ps
module sram_ctl_test;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int CLK = 5;
  localparam int PWR_NS = 2000;

  function automatic int up(input int ns);
    int c = 0;
    while (c * CLK < ns) c++;
    if (c == 0) c = 1;
    return c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_PWR = PWR_NS / CLK + ((PWR_NS % CLK) != 0 ? 1 : 0);
  int e_rd, e_pw, e_wtot, e_rc;

  logic clk = 0, rst_n = 0;
  logic req = 0, req_wr = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ready, rvalid, ce_n, oe_n, we_n;
  logic [DW-1:0] rdata;
  logic [AW-1:0] sram_addr;
  wire  [DW-1:0] sram_dq;

  sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK), .T_PWR_NS(PWR_NS)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rdata(rdata), .rvalid(rvalid),
    .sram_addr(sram_addr), .sram_dq(sram_dq), .sram_ce_n(ce_n),
    .sram_oe_n(oe_n), .sram_we_n(we_n)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  // RAM model
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW-1:0] shadow [0:(1<<AW)-1];
  logic mdrv = 0;
  logic [DW-1:0] mval = '0;
  assign sram_dq = mdrv ? mval : 'z;

  logic p_ce = 1, p_oe = 1, p_we = 1, was_wr = 0, pwr_seen = 0;
  logic [AW-1:0] p_addr = '0;
  int we_run = 0, oe_run = 0, ce_run = 0, gap = 1000, a_age = 0, o_age = 0;
  int ops = 0, issued = 0;
  logic [DW-1:0] cur_wd = '0;

  always @(negedge clk) if (rst_n) begin
    if (ready) pwr_seen = 1;
    if (!pwr_seen) chk(ce_n == 1'b1, "R1 select during power-up", ce_n, 1);
    if (ready) chk(ce_n && oe_n && we_n, "R9 idle strobes", {ce_n, oe_n, we_n}, 7);
    if (!oe_n) chk(we_n && p_we, "R6 output enable during write", {we_n, p_we}, 3);
    if (!we_n) begin
      chk(sram_dq == cur_wd, "R6 write data on bus", sram_dq, cur_wd);
      chk(sram_addr == p_addr && !ce_n, "R4 address held", sram_addr, p_addr);
      if (p_we) chk(!p_ce, "R4 select before strobe", p_ce, 0);
    end
    if (we_n && !p_we) chk(we_run == e_pw, "R5 strobe width", we_run, e_pw);
    if (oe_n && !p_oe) chk(oe_run == e_rd, "R3 read window", oe_run, e_rd);
    if (ce_n && !p_ce && was_wr) begin
      chk(ce_run == e_wtot, "R7 write length", ce_run, e_wtot);
      was_wr = 0;
    end
    if (sram_addr != p_addr) begin
      chk(gap >= e_rc, "R8 address spacing", gap, e_rc);
      gap = 1;
    end else gap++;
    if (!ce_n && p_ce) ops++;
    if (!we_n) was_wr = 1;
    we_run = we_n ? 0 : we_run + 1;
    oe_run = oe_n ? 0 : oe_run + 1;
    ce_run = ce_n ? 0 : ce_run + 1;
    // model: write while select and strobe low, read data valid only after access times
    if (!ce_n && !we_n) mem[sram_addr] = sram_dq;
    a_age = (sram_addr != p_addr) ? 0 : a_age + 1;
    o_age = (!oe_n && p_oe) ? 0 : o_age + 1;
    mdrv = !ce_n && !oe_n && we_n;
    mval = ((a_age + 1) * CLK >= 12 && (o_age + 1) * CLK >= 6) ? mem[sram_addr] : ~mem[sram_addr];
    p_ce = ce_n; p_oe = oe_n; p_we = we_n; p_addr = sram_addr;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL R2 watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic op(input bit w, input int a, input logic [DW-1:0] d, input bit junk);
    while (!ready) @(negedge clk);
    req = 1; req_wr = w; req_addr = AW'(a); req_wdata = d;
    if (w) begin cur_wd = d; shadow[a] = d; end
    @(negedge clk);
    issued++;
    if (junk) begin
      // R2: request held while busy must be ignored
      req_wr = !w; req_addr = ~AW'(a); req_wdata = ~d;
      @(negedge clk);
      @(negedge clk);
    end
    req = 0;
    if (!w) begin
      while (!rvalid) @(negedge clk);
      chk(rdata == shadow[a], "R10 read back", rdata, shadow[a]);
      @(negedge clk);
      chk(!rvalid, "R3 valid one cycle", rvalid, 0);
    end
  endtask

  initial begin
    int n;
    int unsigned sd;
    e_rd = mx(mx(up(12), up(12)), mx(up(12), up(6)));
    e_pw = mx(up(10), up(7));
    e_wtot = 1 + e_pw + mx(1, mx(up(12), up(13)) - 1 - e_pw);
    e_rc = up(12);
    for (int i = 0; i < (1 << AW); i++) begin
      mem[i] = DW'(i * 37 + 5);
      shadow[i] = DW'(i * 37 + 5);
    end
    sd = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && we_n, "R9 reset strobes", {ce_n, oe_n, we_n}, 7);
    chk(!ready && !rvalid, "R1 reset ready", ready, 0);
    rst_n = 1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      req = (n >= 10 && n < 14); // R2: requests during power-up
      req_wr = 1;
    end while (!ready);
    req = 0;
    chk(n == E_PWR, "R1 power-up length", n, E_PWR);
    chk(ops == 0, "R2 no access during power-up", ops, 0);
    // directed corners
    op(1, 0, 16'hFFFF, 0);
    op(0, 0, '0, 0);
    op(1, (1 << AW) - 1, 16'h0000, 1);
    op(0, (1 << AW) - 1, '0, 1);
    op(1, 5, 16'hA5C3, 0);
    op(1, 5, 16'h5A3C, 0);
    op(0, 5, '0, 0);
    op(0, 6, '0, 0);
    // random mix on a small address window for read-after-write hits
    for (int k = 0; k < 300; k++) begin
      int a;
      a = int'($urandom % 16) + ((k % 3 == 0) ? int'($urandom % (1 << AW)) : 0);
      a = a % (1 << AW);
      op(($urandom % 2) == 1, a, DW'($urandom), ($urandom % 4) == 0);
    end
    repeat (10) @(negedge clk);
    chk(ops == issued, "R2 accepted count", ops, issued);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule